// File: doc/BRIEF.md
# Programmable Test Pattern Sequencer

This block sits between a converter's 16-bit sample path and its output pins. When the test mode is off, each sample strobe passes the live converter word to the output. When the test mode is on, the block replaces the live word with known test words, so that a receiving device can check board timing and connectivity.

Eight sequence slots each hold a 3-bit pattern code. Six codes select built-in words. Two codes select 16-bit words that software writes into the register file. On each sample strobe in test mode, the block emits the word that the current slot selects and moves to the next slot. After slot 7 it wraps to slot 0. The register-file bytes arrive as plain input buses. The block reads them at every strobe, so a change to the configuration takes effect on the next strobe.

A two-state controller sets the mode. `ST_BYPASS` holds the slot pointer and the word index at zero. The transition *arm* (a strobe with the enable high) moves it to `ST_PATTERN`. In `ST_PATTERN` each strobe with the enable high is a *step*, which advances the pointer and the index. A strobe with the enable low is the transition *disarm*: it returns the controller to `ST_BYPASS` and clears both counters.

Top module: `tpat_sequencer`

## Requirements
- R1: While reset is held, and after it is released, `out_word` is 0x0000 and `out_valid` is 0 until the first strobe.
- R2: A strobe (`smp_tick` high at a rising clock edge) makes `out_valid` 1 for exactly the following cycle, and `out_word` takes its new value at that same edge. Without a strobe, `out_valid` is 0 and `out_word` holds its value. A strobe with `tp_enable` low outputs `live_word`.
- R3: In test mode the first word after arming comes from slot 0. Each later strobe uses the next slot, and slot 7 is followed by slot 0.
- R4: Slot packing: byte k of `slot_cfg` (bits 8k+7:8k, register 0x08+k) holds slot 2k in bits 2:0 and slot 2k+1 in bits 6:4. Bits 3 and 7 of each byte have no effect on the output.
- R5: Fixed codes: 000 gives 0x0000, 001 gives 0xFFFF, 011 gives 0x5555, 100 gives 0xAAAA.
- R6: Code 010 gives 0xFF00 when the word index is even and 0x00FF when it is odd. The word index counts the test words emitted since arming, starting at 0.
- R7: Code 101 gives the word index itself, a ramp that wraps from 0xFFFF to 0x0000.
- R8: Code 110 gives {byte0, byte1} of `user_cfg`, and code 111 gives {byte2, byte3}. Byte k sits in bits 8k+7:8k (register 0x0C+k), and the byte at the lower address is the high byte.
- R9: A strobe with `tp_enable` low returns the output to `live_word` at that strobe and clears the slot pointer and the word index. The next arming therefore starts again at slot 0 with index 0.
- R10: Configuration bytes are read at the strobe itself, so a change made between two strobes shows up in the word of the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | Sample strobe, one cycle per sample |
| tp_enable | input | 1 | Test-pattern mode enable |
| live_word | input | 16 | Live converter sample |
| slot_cfg | input | 32 | Slot-select register bytes 0x08..0x0B |
| user_cfg | input | 32 | User pattern register bytes 0x0C..0x0F |
| out_word | output | 16 | Output sample or test word |
| out_valid | output | 1 | One-cycle flag after each strobe |

## Verification
The hardest case to reach is the ramp wrap from 0xFFFF to 0x0000. It needs more than 65,536 test words in a row with no disarm in between. The stimulus gets there with a directed run that sets every slot to code 101 and holds the enable high for 65,540 back-to-back strobes. Seeded random phases then mix arming and disarming, idle gaps and configuration changes between strobes, with junk in the ignored bits. A bench model of the pointer and index predicts every word.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [0:0] {
        ST_BYPASS  = 1'b0,
        ST_PATTERN = 1'b1
    } tp_state_e;

    localparam logic [CODE_W-1:0] PC_ZEROS  = 3'b000;
    localparam logic [CODE_W-1:0] PC_ONES   = 3'b001;
    localparam logic [CODE_W-1:0] PC_TOGGLE = 3'b010;
    localparam logic [CODE_W-1:0] PC_LOW01  = 3'b011;
    localparam logic [CODE_W-1:0] PC_HIGH10 = 3'b100;
    localparam logic [CODE_W-1:0] PC_RAMP   = 3'b101;
    localparam logic [CODE_W-1:0] PC_USER_A = 3'b110;
    localparam logic [CODE_W-1:0] PC_USER_B = 3'b111;

endpackage

// File: rtl/tpat_seq_ctrl.sv
module tpat_seq_ctrl
    import tpat_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int IDX_W  = 16,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    output tp_state_e        state,
    output logic [PTR_W-1:0] ptr,
    output logic [IDX_W-1:0] idx
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);

    tp_state_e state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BYPASS;
        else        state <= state_nxt;
    end

    // transitions: arm, step, disarm
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BYPASS:  if (tick && enable)  state_nxt = ST_PATTERN;
            ST_PATTERN: if (tick && !enable) state_nxt = ST_BYPASS;
            default:    state_nxt = ST_BYPASS;
        endcase
    end

    // slot pointer and word index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            idx <= '0;
        end else if (tick) begin
            if (enable) begin
                ptr <= (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;
                idx <= idx + 1'b1;
            end else begin
                ptr <= '0;
                idx <= '0;
            end
        end
    end

    // R9: outside test mode the counters wait at zero
    p_bypass_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> (ptr == '0 && idx == '0));

    // R3: the last slot is followed by slot 0
    p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && enable && ptr == LAST_SLOT) |=> (ptr == '0));

    // R3: counters move only on strobes
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(ptr) && $stable(idx)));

    // R7: index advances by one per test word
    p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && enable) |=> (idx == IDX_W'($past(idx) + 1'b1)));

endmodule

// File: rtl/tpat_slot_pick.sv
module tpat_slot_pick
    import tpat_pkg::*;
#(
    parameter int SLOTS  = 8,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int REG_N = SLOTS / 2
) (
    input  logic [REG_N*8-1:0] slot_cfg,
    input  logic [PTR_W-1:0]   sel,
    output logic [CODE_W-1:0]  code
);

    logic [CODE_W-1:0] codes [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign codes[s] = slot_cfg[(s/2)*8 + (s%2)*4 +: CODE_W];
    end

    // bits 3 and 7 of every byte carry no meaning
    logic unused_spare;
    assign unused_spare = ^slot_cfg;

    assign code = codes[sel];

endmodule

// File: rtl/tpat_pattern_gen.sv
module tpat_pattern_gen
    import tpat_pkg::*;
#(
    parameter int WORD_W  = 16,
    localparam int HALF   = WORD_W / 2,
    localparam int NBYTES = WORD_W / 8
) (
    input  logic [CODE_W-1:0]   code,
    input  logic [WORD_W-1:0]   idx,
    input  logic [2*WORD_W-1:0] user_cfg,
    output logic [WORD_W-1:0]   word
);

    logic [WORD_W-1:0] user_a;
    logic [WORD_W-1:0] user_b;

    // lower register address lands in the high byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign user_a[(NBYTES-1-b)*8 +: 8] = user_cfg[b*8 +: 8];
        assign user_b[(NBYTES-1-b)*8 +: 8] = user_cfg[WORD_W + b*8 +: 8];
    end

    always_comb begin
        unique case (code)
            PC_ZEROS:  word = '0;
            PC_ONES:   word = '1;
            PC_TOGGLE: word = idx[0] ? {{HALF{1'b0}}, {HALF{1'b1}}}
                                     : {{HALF{1'b1}}, {HALF{1'b0}}};
            PC_LOW01:  word = {HALF{2'b01}};
            PC_HIGH10: word = {HALF{2'b10}};
            PC_RAMP:   word = idx;
            PC_USER_A: word = user_a;
            PC_USER_B: word = user_b;
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/tpat_sequencer.sv
module tpat_sequencer
    import tpat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 8,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int SCFG_W = (SLOTS / 2) * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_tick,
    input  logic                tp_enable,
    input  logic [WORD_W-1:0]   live_word,
    input  logic [SCFG_W-1:0]   slot_cfg,
    input  logic [2*WORD_W-1:0] user_cfg,
    output logic [WORD_W-1:0]   out_word,
    output logic                out_valid
);

    tp_state_e          state;
    logic [PTR_W-1:0]   ptr;
    logic [WORD_W-1:0]  idx;
    logic [CODE_W-1:0]  code;
    logic [WORD_W-1:0]  pat_word;

    tpat_seq_ctrl #(.SLOTS(SLOTS), .IDX_W(WORD_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_tick),
        .enable (tp_enable),
        .state  (state),
        .ptr    (ptr),
        .idx    (idx)
    );

    tpat_slot_pick #(.SLOTS(SLOTS)) u_pick (
        .slot_cfg (slot_cfg),
        .sel      (ptr),
        .code     (code)
    );

    tpat_pattern_gen #(.WORD_W(WORD_W)) u_gen (
        .code     (code),
        .idx      (idx),
        .user_cfg (user_cfg),
        .word     (pat_word)
    );

    logic unused_state;
    assign unused_state = (state == ST_PATTERN);

    // output register: bypass mux
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_tick;
            if (smp_tick) out_word <= tp_enable ? pat_word : live_word;
        end
    end

    // R2: valid follows every strobe for one cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |=> out_valid);

    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> !out_valid);

    // R2: word holds between strobes
    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(out_word));

    // R9: disabled strobe passes the live sample
    p_bypass_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_tick && !tp_enable) |=> (out_word == $past(live_word)));

endmodule

// File: tb/tpat_sequencer_test.sv
module tpat_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b0;
    logic        tp_enable = 1'b0;
    logic [15:0] live_word = '0;
    logic [31:0] slot_cfg = 32'h2222_2222;
    logic [31:0] user_cfg = '0;
    logic [15:0] out_word;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model
    int          m_ptr = 0;
    logic [15:0] m_idx = '0;
    logic [15:0] last_exp = '0;

    always #10 clk = ~clk;

    tpat_sequencer uut (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .tp_enable(tp_enable),
        .live_word(live_word), .slot_cfg(slot_cfg), .user_cfg(user_cfg),
        .out_word(out_word), .out_valid(out_valid)
    );

    function automatic logic [2:0] slot_code(logic [31:0] cfg, int p);
        return 3'((cfg >> ((p / 2) * 8 + (p % 2) * 4)) & 32'h7);
    endfunction

    function automatic logic [15:0] pat_value(logic [2:0] c, logic [15:0] ix,
                                              logic [31:0] ucfg);
        case (c)
            3'd0: return 16'h0000;
            3'd1: return 16'hFFFF;
            3'd2: return ix[0] ? 16'h00FF : 16'hFF00;
            3'd3: return 16'h5555;
            3'd4: return 16'hAAAA;
            3'd5: return ix;
            3'd6: return {ucfg[7:0], ucfg[15:8]};
            default: return {ucfg[23:16], ucfg[31:24]};
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one strobe, called at a falling edge; returns at the next falling edge
    task automatic strobe(input logic en, input logic [15:0] live, input string req);
        logic [15:0] exp;
        smp_tick  = 1'b1;
        tp_enable = en;
        live_word = live;
        if (en) begin
            exp   = pat_value(slot_code(slot_cfg, m_ptr), m_idx, user_cfg);
            m_ptr = (m_ptr + 1) % 8;
            m_idx = m_idx + 16'd1;
        end else begin
            exp   = live;
            m_ptr = 0;
            m_idx = '0;
        end
        @(posedge clk);
        @(negedge clk);
        smp_tick = 1'b0;
        last_exp = exp;
        check(req, out_word, exp);
        check({req, " valid"}, 16'(out_valid), 16'd1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 hold", out_word, last_exp);
            check("R2 quiet valid", 16'(out_valid), 16'd0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset word", out_word, 16'h0000);
        check("R1 reset valid", 16'(out_valid), 16'd0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", out_word, 16'h0000);

        // R2: live passthrough
        strobe(1'b0, 16'hBEEF, "R2 live");
        strobe(1'b0, 16'h1357, "R2 live");
        idle(3);

        // R6: default slots all code 010
        for (int i = 0; i < 10; i++) strobe(1'b1, 16'h0, "R6 toggle default");
        strobe(1'b0, 16'hC0DE, "R9 disarm");

        // R3 R5 R8: walk codes 0..7 by slot
        slot_cfg = 32'h7654_3210;
        user_cfg = 32'h7856_3412;
        for (int i = 0; i < 16; i++) strobe(1'b1, 16'h0, "R3 R5 R8 walk");
        strobe(1'b0, 16'h0F0F, "R9 disarm");
        // R4: ignored bits 3 and 7 set, same codes
        slot_cfg = 32'hFEDC_BA98;
        for (int i = 0; i < 16; i++) strobe(1'b1, 16'h0, "R4 spare bits");
        // R9: disarm mid-sequence, re-arm from slot 0
        strobe(1'b1, 16'h0, "R3 walk");
        strobe(1'b1, 16'h0, "R3 walk");
        strobe(1'b0, 16'hAAA5, "R9 disarm mid");
        strobe(1'b1, 16'h0, "R9 rearm slot0");
        // R10: change config between strobes
        slot_cfg = 32'h6666_6666;
        user_cfg = 32'h0000_CDAB;
        strobe(1'b1, 16'h0, "R10 new cfg");
        idle(2);
        user_cfg = 32'h0000_2211;
        strobe(1'b1, 16'h0, "R10 new user word");
        strobe(1'b0, 16'h0, "R9 disarm");

        // R7: ramp wrap over 65,540 words
        slot_cfg = 32'h5555_5555;
        for (int i = 0; i < 65540; i++) strobe(1'b1, 16'h0, "R7 ramp");
        strobe(1'b0, 16'h4242, "R9 disarm");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) slot_cfg = $urandom;
            if ($urandom_range(0, 15) == 0) user_cfg = $urandom;
            if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
            strobe($urandom_range(0, 7) != 0, 16'($urandom), "R3 R9 random");
        end
        idle(2);
        finish_run();
    end

endmodule